// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog

A memory-mapped system timer. One 32-bit up-counter advances on each clock in which an external tick-enable is high. Four 32-bit compare registers are checked against it. When the counter steps into a compare value and that channel's enable bit is set, the channel latches an event bit and drives its interrupt line. Software clears each event by writing a one to the event bit's position in the status register.

Software reaches the block through a single-cycle register port. Writes take effect at the clock edge where the write enable is sampled. Reads return the addressed register combinationally. The count rate comes from whatever drives the tick-enable, typically a divided 3.6864 MHz or 3.25 MHz reference.

Compare channel 3 can also serve as a watchdog. Once software arms it, a step of the counter into compare value 3 raises a reset request that stays high until the block is reset.

Top module: `match_timer`

## Requirements
- R1: After reset the counter, all compare registers, the status bits, the enable register and the watchdog arm bit read zero, and `irq` and `wdtReset` are low.
- R2: In each clock cycle with `tickEn` high and no counter write, the counter rises by one and wraps from 0xFFFFFFFF to 0. With `tickEn` low it holds.
- R3: Writing offset 0x10 loads the counter with `wrData`. This load beats a tick in the same cycle, and counting resumes from the loaded value.
- R4: Compare register n (n = 0..3) sits at byte offset 4·n. It is written and read back in full.
- R5: When a tick moves the counter onto the value of compare register n and enable bit n is set, status bit n and `irq[n]` go high at that same clock edge. None of the following sets an event:
  - loading the counter with an equal value,
  - writing a compare register equal to the current count,
  - holding an equal value without ticks.
- R6: With enable bit n clear, a match on channel n leaves status bit n and `irq[n]` low.
- R7: A write to the status register at 0x14 clears each event bit 0..3 written as 1, together with its `irq` line. Bits written as 0 keep their value. An event that arises in the same cycle as the clear is kept.
- R8: The enable register at 0x1c stores `wrData[11:0]`. Bits 31..12 are dropped and read as zero. Bits 3..0 gate channels 3..0.
- R9: Writing offset 0x18 with bit 0 set arms the watchdog. Writing 0 there does not disarm it; only reset does. Bit 0 of a read at 0x18 returns the arm state.
- R10: While armed, a tick that moves the counter onto compare value 3 raises `wdtReset` at that edge. It stays high until reset, whatever enable bit 3 holds.
- R11: Offsets outside 0x00–0x1c, and offsets not on a 4-byte boundary, read as zero, and writes to them change no register.
- R12: `rdData` reflects the register selected by `addr` in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count enable, one count per cycle while high |
| addr | input | 8 | Byte offset of the register accessed |
| wrEn | input | 1 | Write strobe for the addressed register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| irq | output | 4 | Per-channel interrupt lines |
| wdtReset | output | 1 | Sticky system reset request from the watchdog |

## Verification
The checker watches every cycle for these properties:
- the counter steps by one or holds, depending on the tick;
- a full status clear without a tick drops all interrupt lines;
- interrupts rise only after a tick;
- the reset request is sticky;
- unused enable bits and unmapped offsets read as zero.

Only the bench's scenarios can show the rest:
- that events follow compare values and the enable mask;
- that a set beats a clear in the same cycle;
- that equality without a tick stays silent;
- that the watchdog fires with channel 3 masked and cannot be disarmed.

These scenarios sweep every enable mask and every clear pattern, with expected values worked out arithmetically.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int CH_NUM = 4;

  localparam logic [7:0] OFS_CNT  = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_WDT  = 8'h18;
  localparam logic [7:0] OFS_EN   = 8'h1c;

  typedef enum logic [2:0] {
    SEL_MATCH, SEL_CNT, SEL_STAT, SEL_WDT, SEL_EN, SEL_NONE
  } mtSel_t;

  typedef struct packed {
    logic [CH_NUM-1:0] ldMatch;
    logic              ldCnt;
    logic              clrStat;
    logic              ldEn;
    logic              setWdt;
  } mtStrobe_t;
endpackage

// File: rtl/match_timer_ctrl.sv
module match_timer_ctrl
  import match_timer_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output mtSel_t            rdSel,
  output logic [1:0]        rdIdx,
  output mtStrobe_t         strobe
);
  logic aligned;
  logic inMatch;

  assign aligned = (addr[1:0] == 2'b00);
  assign inMatch = aligned && (addr[ADDR_W-1:4] == '0);
  assign rdIdx   = addr[3:2];

  always_comb begin
    rdSel = SEL_NONE;
    if (inMatch) rdSel = SEL_MATCH;
    else if (addr == ADDR_W'(OFS_CNT))  rdSel = SEL_CNT;
    else if (addr == ADDR_W'(OFS_STAT)) rdSel = SEL_STAT;
    else if (addr == ADDR_W'(OFS_WDT))  rdSel = SEL_WDT;
    else if (addr == ADDR_W'(OFS_EN))   rdSel = SEL_EN;
  end

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      unique case (rdSel)
        SEL_MATCH: strobe.ldMatch[rdIdx] = 1'b1;
        SEL_CNT:   strobe.ldCnt   = 1'b1;
        SEL_STAT:  strobe.clrStat = 1'b1;
        SEL_WDT:   strobe.setWdt  = 1'b1;
        SEL_EN:    strobe.ldEn    = 1'b1;
        default:   strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/match_timer_dp.sv
module match_timer_dp
  import match_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int EN_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  mtStrobe_t         strobe,
  input  mtSel_t            rdSel,
  input  logic [1:0]        rdIdx,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [CH_NUM-1:0] irq,
  output logic              wdtReset
);
  localparam int CH_MSB = CH_NUM - 1;

  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  cntNext;
  logic [CNT_W-1:0]  matchQ [CH_NUM];
  logic [CH_NUM-1:0] statQ;
  logic [EN_W-1:0]   enQ;
  logic              wdtEnQ;
  logic              wdtRstQ;
  logic [CH_NUM-1:0] hit;
  logic [CH_NUM-1:0] setVec;
  logic [CH_NUM-1:0] clrVec;
  logic              stepping;

  assign cntNext  = cntQ + 1'b1;
  assign stepping = tickEn && !strobe.ldCnt;

  always_ff @(posedge clk) begin
    if (!rstN)             cntQ <= '0;
    else if (strobe.ldCnt) cntQ <= wrData;
    else if (tickEn)       cntQ <= cntNext;
  end

  for (genvar n = 0; n < CH_NUM; n++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN)                 matchQ[n] <= '0;
      else if (strobe.ldMatch[n]) matchQ[n] <= wrData;
    end
    assign hit[n] = stepping && (cntNext == matchQ[n]);
  end

  assign setVec = hit & enQ[CH_MSB:0];
  assign clrVec = strobe.clrStat ? wrData[CH_MSB:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ   <= '0;
      enQ     <= '0;
      wdtEnQ  <= 1'b0;
      wdtRstQ <= 1'b0;
    end else begin
      statQ   <= (statQ & ~clrVec) | setVec;
      if (strobe.ldEn) enQ <= wrData[EN_W-1:0];
      wdtEnQ  <= wdtEnQ | (strobe.setWdt & wrData[0]);
      wdtRstQ <= wdtRstQ | (wdtEnQ & hit[CH_MSB]);
    end
  end

  assign irq      = statQ;
  assign wdtReset = wdtRstQ;

  always_comb begin
    unique case (rdSel)
      SEL_MATCH: rdData = matchQ[rdIdx];
      SEL_CNT:   rdData = cntQ;
      SEL_STAT:  rdData = CNT_W'(statQ);
      SEL_WDT:   rdData = CNT_W'(wdtEnQ);
      SEL_EN:    rdData = CNT_W'(enQ);
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int EN_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [CH_NUM-1:0] irq,
  output logic              wdtReset
);
  mtStrobe_t  strobe;
  mtSel_t     rdSel;
  logic [1:0] rdIdx;

  match_timer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr(addr), .wrEn(wrEn), .rdSel(rdSel), .rdIdx(rdIdx), .strobe(strobe)
  );

  match_timer_dp #(.CNT_W(CNT_W), .EN_W(EN_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .rdSel(rdSel), .rdIdx(rdIdx), .wrData(wrData), .rdData(rdData),
    .irq(irq), .wdtReset(wdtReset)
  );
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
  import match_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int EN_W   = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [CNT_W-1:0]  wrData,
  input logic [CNT_W-1:0]  rdData,
  input logic [CH_NUM-1:0] irq,
  input logic              wdtReset
);
  logic atCnt;
  logic mapped;

  assign atCnt  = (addr == ADDR_W'(OFS_CNT));
  assign mapped = (addr[1:0] == 2'b00) && (addr <= ADDR_W'(OFS_EN));

  // R2: a tick with no write moves the counter up by exactly one
  a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rstN)
    (atCnt && tickEn && !wrEn) |=> (!atCnt || rdData == $past(rdData) + 1'b1));

  // R2: with no tick and no write the counter holds
  a_r2_cnt_hold: assert property (@(posedge clk) disable iff (!rstN)
    (atCnt && !tickEn && !wrEn) |=> (!atCnt || rdData == $past(rdData)));

  // R7: clearing every event bit in a cycle without a tick drops all lines
  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFS_STAT) && wrData[CH_NUM-1:0] == '1 && !tickEn)
      |=> (irq == '0));

  // R5: an interrupt line only rises after a tick
  a_r5_irq_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> ((irq & ~$past(irq)) == '0));

  // R10: the watchdog reset request is sticky
  a_r10_wdt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    wdtReset |=> wdtReset);

  // R8: the unused enable bits read as zero
  a_r8_en_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(OFS_EN)) |-> (rdData[CNT_W-1:EN_W] == '0));

  // R11: unmapped offsets read as zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> (rdData == '0));
endmodule

bind match_timer match_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .EN_W(EN_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
  .wrData(wrData), .rdData(rdData), .irq(irq), .wdtReset(wdtReset)
);

// File: tb/match_timer_bench.sv
module match_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  irq;
  logic        wdtReset;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  match_timer u_match_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .irq(irq), .wdtReset(wdtReset)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; tickEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1; tickEn = tk;
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wrEn = 1'b0;
    #1 d = rdData;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] base;

    doReset();
    // R1: reset state
    for (int a = 0; a <= 8'h1c; a += 4) begin
      rd(8'(a), d);
      chk("R1 reset reg", d, 32'h0);
    end
    chk("R1 irq", {28'h0, irq}, 32'h0);
    chk("R1 wdtReset", {31'h0, wdtReset}, 32'h0);

    // R4: compare register readback
    for (int n = 0; n < 4; n++) wr(8'(4 * n), 32'hA5A5_0000 + 32'(n * 7));
    for (int n = 0; n < 4; n++) begin
      rd(8'(4 * n), d);
      chk("R4 match readback", d, 32'hA5A5_0000 + 32'(n * 7));
    end

    // R8: enable masking
    wr(8'h1c, 32'hFFFF_FFFF);
    rd(8'h1c, d);
    chk("R8 enable 12 bits", d, 32'h0000_0FFF);

    // R11: unmapped and misaligned
    wr(8'h20, 32'h1234_5678);
    wr(8'h11, 32'h1234_5678);
    rd(8'h20, d); chk("R11 unmapped read", d, 32'h0);
    rd(8'h13, d); chk("R11 misaligned read", d, 32'h0);
    rd(8'h10, d); chk("R11 write ignored", d, 32'h0);

    // R12: combinational read
    @(negedge clk); addr = 8'h1c; #1 chk("R12 same-cycle read", rdData, 32'h0FFF);
    addr = 8'h04; #1 chk("R12 same-cycle read", rdData, 32'hA5A5_0007);

    // R2 R3 R5 R6: sweep every enable mask; base chosen so some sweeps wrap
    for (int mask = 0; mask < 16; mask++) begin
      base = {mask[3:0], 28'h0} - 32'd2;
      wr(8'h1c, 32'(mask));
      wr(8'h14, 32'hF);
      for (int n = 0; n < 4; n++) wr(8'(4 * n), base + 32'(n + 1));
      wr(8'h10, base);
      rd(8'h14, d);
      chk("R5 no event on load", d, 32'h0);
      for (int k = 1; k <= 4; k++) begin
        tick(1);
        rd(8'h10, d);
        chk("R2 count step", d, base + 32'(k));
        rd(8'h14, d);
        chk("R5 R6 status mask", d, 32'(mask & ((1 << k) - 1)));
        chk("R5 R6 irq mask", {28'h0, irq}, 32'(mask & ((1 << k) - 1)));
      end
    end

    // R2: hold without tick
    rd(8'h10, d); base = d;
    repeat (5) @(negedge clk);
    rd(8'h10, d); chk("R2 hold", d, base);

    // R3: load beats tick in the same cycle
    wr(8'h10, 32'h0000_1000, 1'b1);
    rd(8'h10, d); chk("R3 load priority", d, 32'h0000_1000);
    tick(3);
    rd(8'h10, d); chk("R3 resume from load", d, 32'h0000_1003);

    // R5: static equality does not trigger
    wr(8'h1c, 32'hF);
    wr(8'h14, 32'hF);
    wr(8'h00, 32'h0000_1003);
    repeat (4) @(negedge clk);
    rd(8'h14, d); chk("R5 no event on compare write", d, 32'h0);

    // R7: sweep all clear patterns
    for (int pat = 0; pat < 16; pat++) begin
      wr(8'h14, 32'hF);
      for (int n = 0; n < 4; n++) wr(8'(4 * n), 32'd100 + 32'(n));
      wr(8'h10, 32'd99);
      tick(4);
      wr(8'h14, 32'hFFFF_FFF0 | 32'(pat));
      rd(8'h14, d);
      chk("R7 clear pattern", d, 32'(4'hF & ~pat[3:0]));
      chk("R7 irq after clear", {28'h0, irq}, 32'(4'hF & ~pat[3:0]));
    end

    // R7: set wins over clear in the same cycle
    wr(8'h14, 32'hF);
    wr(8'h10, 32'd99);
    wr(8'h14, 32'h1, 1'b1);
    rd(8'h14, d); chk("R7 set beats clear", d, 32'h1);

    // R9 R10: watchdog with channel 3 masked
    wr(8'h1c, 32'h0);
    wr(8'h14, 32'hF);
    wr(8'h0c, 32'd500);
    wr(8'h10, 32'd498);
    tick(1);
    chk("R10 no reset before arm", {31'h0, wdtReset}, 32'h0);
    wr(8'h18, 32'h1);
    rd(8'h18, d); chk("R9 arm readback", d, 32'h1);
    wr(8'h18, 32'h0);
    rd(8'h18, d); chk("R9 not disarmed by write", d, 32'h1);
    wr(8'h10, 32'd498);
    tick(1);
    chk("R10 no reset before match", {31'h0, wdtReset}, 32'h0);
    tick(1);
    chk("R10 reset request", {31'h0, wdtReset}, 32'h1);
    chk("R10 irq3 masked", {28'h0, irq}, 32'h0);
    tick(3);
    chk("R10 sticky", {31'h0, wdtReset}, 32'h1);

    doReset();
    chk("R1 reset clears request", {31'h0, wdtReset}, 32'h0);
    rd(8'h18, d); chk("R1 reset disarms", d, 32'h0);

    finish_run();
  end
endmodule